// File: doc/BRIEF.md
# DAC Channel Trigger and Wave Generator

This block is the digital control core of one digital-to-analog converter channel. It keeps the channel's control word (channel on, calibration mode, trigger gating, trigger source, wave mode and mask/amplitude code) and a 12-bit holding value. From these it produces the 12-bit code that feeds the converter.

With trigger gating off, the output code follows the holding value one clock later. With trigger gating on, the output changes only when the selected trigger arrives. The source is either the rising edge of one of seven external lines or a software strobe. On each trigger the channel can add a value from a pseudo-noise generator or a triangle generator to the holding value. The mask/amplitude code limits that added value. A bit in the control word requests calibration mode for the analog side. That bit can only change while the channel is off.

Top module: `dac_wave_chan`

## Requirements
- R1: After synchronous reset, `dout` is 0, `cal_active` is 0 and every control field is 0.
- R2: A `ctl_wr` pulse loads `ctl_wdata` into the control word at that edge. The layout is: bit 0 channel on, bit 1 calibration request, bit 2 trigger gating, bits 5:3 trigger source, bits 7:6 wave mode, bits 11:8 mask/amplitude code.
- R3: The calibration bit takes the written value only if the channel-on bit stored before the write is 0. Otherwise it keeps its old value, and `cal_active` shows it.
- R4: While the stored channel-on bit is 0, `dout` becomes 0 at every edge. The noise generator returns to seed 12'hACE and the triangle counter returns to 0 counting up.
- R5: With the channel on and trigger gating 0, `dout` takes the holding register at every edge, so it shows a `hold_wr` value one edge after that write. Triggers have no effect in this mode.
- R6: With trigger gating 1, `dout` changes only at an edge where the selected source fires. Source codes 0 to 6 pick the rising edge of `ext_trig[code]`, and a line held high fires once. Code 7 picks `sw_trig`, which updates `dout` at the same edge it is sampled. Unselected sources are ignored.
- R7: With wave mode 00, a trigger loads the holding value unchanged.
- R8: With wave mode 01, each trigger advances a 12-bit LFSR once: next = {s[10:0], s[11]^s[5]^s[3]^s[0]}. `dout` then takes the holding value plus the advanced state ANDed with the mask. The LFSR never holds zero.
- R9: For a mask/amplitude code n below 11, the mask and the triangle peak are 2^(n+1)-1. For codes 11 to 15 they are 4095.
- R10: With wave mode 10 or 11, each trigger steps the triangle counter up by one until it reaches the peak, then down by one to 0, and repeats. `dout` takes the holding value plus the stepped count.
- R11: The sum of holding value and wave value is truncated to 12 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 12 | Control word to write |
| hold_wr | input | 1 | Holding value write strobe |
| hold_data | input | 12 | Holding value |
| ext_trig | input | 7 | External trigger lines |
| sw_trig | input | 1 | Software trigger strobe |
| dout | output | 12 | Registered converter code |
| cal_active | output | 1 | Stored calibration request |

## Verification
A wrong generator state appears at `dout` at the first trigger after the fault. From then on the sequence stays off the model: a noise slip shows in the unmasked low bits, and a triangle slip shows as a wrong turning point. A broken write guard on the calibration bit appears on `cal_active` right after the offending write. A trigger-selection fault appears at the trigger edge itself, as an update that is missing or not expected. The bench compares `dout` with a model after every trigger and after every write.

// File: rtl/dwg_pkg.sv
package dwg_pkg;
  localparam int DWG_DATA_W = 12;
  localparam int DWG_TSEL_W = 3;
  localparam int DWG_MAMP_W = 4;

  typedef enum logic [1:0] {
    WAVE_OFF   = 2'b00,
    WAVE_NOISE = 2'b01,
    WAVE_TRI_A = 2'b10,
    WAVE_TRI_B = 2'b11
  } wave_mode_e;

  typedef struct packed {
    logic [DWG_MAMP_W-1:0] mamp;
    wave_mode_e            wave;
    logic [DWG_TSEL_W-1:0] tsel;
    logic                  tgate;
    logic                  cal;
    logic                  on;
  } ctl_word_t;

  localparam int DWG_CTL_W = $bits(ctl_word_t);
endpackage

// File: rtl/dwg_ctrl_regs.sv
module dwg_ctrl_regs
  import dwg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [DWG_CTL_W-1:0] wdata,
  output ctl_word_t            ctl_q
);
  ctl_word_t wr_word;
  ctl_word_t ctl_nxt;

  always_comb begin
    wr_word = ctl_word_t'(wdata);
    ctl_nxt = wr_word;
    // calibration request is frozen while the channel is running
    ctl_nxt.cal = ctl_q.on ? ctl_q.cal : wr_word.cal;
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else if (wr) ctl_q <= ctl_nxt;
  end

  a_r3_cal_locked: assert property (@(posedge clk) disable iff (rst)
    ctl_q.on |=> (ctl_q.cal == $past(ctl_q.cal)));
endmodule

// File: rtl/dwg_trig_sel.sv
module dwg_trig_sel #(
  parameter int TSEL_W  = 3,
  localparam int NUM_EXT = (1 << TSEL_W) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EXT-1:0] ext_trig,
  input  logic               sw_trig,
  input  logic [TSEL_W-1:0]  sel,
  output logic               hit
);
  logic [NUM_EXT-1:0]     ext_prev_q;
  logic [(1<<TSEL_W)-1:0] src;

  always_ff @(posedge clk) begin
    if (rst) ext_prev_q <= '0;
    else     ext_prev_q <= ext_trig;
  end

  always_comb begin
    src = {sw_trig, ext_trig & ~ext_prev_q};
    hit = src[sel];
  end

  a_r6_sw_only_when_picked: assert property (@(posedge clk) disable iff (rst)
    (sel == TSEL_W'(NUM_EXT)) |-> (hit == sw_trig));
endmodule

// File: rtl/dwg_wave_gen.sv
module dwg_wave_gen
  import dwg_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int MAMP_W = 4,
  parameter logic [DATA_W-1:0] SEED = 12'hACE,
  parameter logic [DATA_W-1:0] TAPS = 12'h829
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step,
  input  wave_mode_e        mode,
  input  logic [MAMP_W-1:0] mamp,
  output logic [DATA_W-1:0] wave_val
);
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] lfsr_q, lfsr_nxt;
  logic [DATA_W-1:0] tri_q, tri_nxt;
  logic              tri_up_q, tri_up_nxt;
  logic              step_noise, step_tri;

  // bit i unmasked when i <= code; codes past the top bit unmask everything
  always_comb begin
    for (int i = 0; i < DATA_W; i++) mask[i] = (i <= int'(mamp));
  end

  always_comb begin
    lfsr_nxt = {lfsr_q[DATA_W-2:0], ^(lfsr_q & TAPS)};
    if (tri_up_q) begin
      if (tri_q < mask) begin tri_nxt = tri_q + 1'b1; tri_up_nxt = 1'b1; end
      else              begin tri_nxt = tri_q - 1'b1; tri_up_nxt = 1'b0; end
    end else begin
      if (tri_q != '0)  begin tri_nxt = tri_q - 1'b1; tri_up_nxt = 1'b0; end
      else              begin tri_nxt = tri_q + 1'b1; tri_up_nxt = 1'b1; end
    end
  end

  assign step_noise = step && (mode == WAVE_NOISE);
  assign step_tri   = step && mode[1];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lfsr_q   <= SEED;
      tri_q    <= '0;
      tri_up_q <= 1'b1;
    end else begin
      if (step_noise) lfsr_q <= lfsr_nxt;
      if (step_tri) begin
        tri_q    <= tri_nxt;
        tri_up_q <= tri_up_nxt;
      end
    end
  end

  always_comb begin
    case (mode)
      WAVE_OFF:   wave_val = '0;
      WAVE_NOISE: wave_val = lfsr_nxt & mask;
      default:    wave_val = tri_nxt;
    endcase
  end

  a_r8_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0);
  a_r8_lfsr_holds: assert property (@(posedge clk) disable iff (rst)
    (!step_noise && !clr) |=> $stable(lfsr_q));
  a_r10_tri_unit_step: assert property (@(posedge clk) disable iff (rst)
    (step_tri && !clr) |=> ((tri_q == $past(tri_q) + 1'b1) || (tri_q == $past(tri_q) - 1'b1)));
endmodule

// File: rtl/dac_wave_chan.sv
module dac_wave_chan
  import dwg_pkg::*;
#(
  parameter int DATA_W = DWG_DATA_W,
  parameter int TSEL_W = DWG_TSEL_W,
  parameter int MAMP_W = DWG_MAMP_W,
  parameter logic [DATA_W-1:0] SEED = 12'hACE,
  parameter logic [DATA_W-1:0] TAPS = 12'h829,
  localparam int NUM_EXT = (1 << TSEL_W) - 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_wr,
  input  logic [DWG_CTL_W-1:0] ctl_wdata,
  input  logic                 hold_wr,
  input  logic [DATA_W-1:0]    hold_data,
  input  logic [NUM_EXT-1:0]   ext_trig,
  input  logic                 sw_trig,
  output logic [DATA_W-1:0]    dout,
  output logic                 cal_active
);
  ctl_word_t         ctl_q;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] wave_val;
  logic              trig_hit;
  logic              step;

  dwg_ctrl_regs i_regs (
    .clk(clk), .rst(rst), .wr(ctl_wr), .wdata(ctl_wdata), .ctl_q(ctl_q)
  );

  dwg_trig_sel #(.TSEL_W(TSEL_W)) i_trig (
    .clk(clk), .rst(rst), .ext_trig(ext_trig), .sw_trig(sw_trig),
    .sel(ctl_q.tsel), .hit(trig_hit)
  );

  assign step = ctl_q.on && ctl_q.tgate && trig_hit;

  dwg_wave_gen #(.DATA_W(DATA_W), .MAMP_W(MAMP_W), .SEED(SEED), .TAPS(TAPS)) i_wave (
    .clk(clk), .rst(rst), .clr(!ctl_q.on), .step(step),
    .mode(ctl_q.wave), .mamp(ctl_q.mamp), .wave_val(wave_val)
  );

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else if (hold_wr) hold_q <= hold_data;
  end

  always_ff @(posedge clk) begin
    if (rst || !ctl_q.on) dout <= '0;
    else if (!ctl_q.tgate) dout <= hold_q;
    else if (trig_hit)     dout <= hold_q + wave_val;
  end

  assign cal_active = ctl_q.cal;

  a_r4_off_zero: assert property (@(posedge clk) disable iff (rst)
    !ctl_q.on |=> (dout == '0));
  a_r5_direct_follow: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.on && !ctl_q.tgate) |=> (dout == $past(hold_q)));
  a_r6_hold_untriggered: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.on && ctl_q.tgate && !trig_hit) |=> $stable(dout));
endmodule

// File: tb/test_dac_wave_chan.sv
`timescale 1ns/1ps
module test_dac_wave_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr = 1'b0;
  logic [11:0] ctl_wdata = '0;
  logic        hold_wr = 1'b0;
  logic [11:0] hold_data = '0;
  logic [6:0]  ext_trig = '0;
  logic        sw_trig = 1'b0;
  logic [11:0] dout;
  logic        cal_active;

  int n_checks = 0;
  int n_fail = 0;
  logic [11:0] lf, tr, hold;
  logic        up;

  always #4 clk = ~clk;

  dac_wave_chan i_dac_wave_chan (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .hold_wr(hold_wr), .hold_data(hold_data), .ext_trig(ext_trig),
    .sw_trig(sw_trig), .dout(dout), .cal_active(cal_active)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(bit on, bit cal, bit tg, int sel, int wave, int mamp);
    ctl_wdata = {4'(mamp), 2'(wave), 3'(sel), tg, cal, on};
    ctl_wr = 1'b1; tick(); ctl_wr = 1'b0;
  endtask

  task automatic wr_hold(logic [11:0] d);
    hold_data = d; hold_wr = 1'b1; tick(); hold_wr = 1'b0; hold = d;
  endtask

  task automatic pulse_sw();
    sw_trig = 1'b1; tick(); sw_trig = 1'b0;
  endtask

  function automatic logic [11:0] lf_next(logic [11:0] s);
    return {s[10:0], s[11] ^ s[5] ^ s[3] ^ s[0]};
  endfunction

  function automatic logic [11:0] mask_of(int n);
    return (n >= 11) ? 12'hFFF : 12'((1 << (n + 1)) - 1);
  endfunction

  task automatic tri_step(int n);
    logic [11:0] pk = mask_of(n);
    if (up) begin
      if (tr < pk) tr = tr + 1; else begin tr = tr - 1; up = 1'b0; end
    end else begin
      if (tr != 0) tr = tr - 1; else begin tr = tr + 1; up = 1'b1; end
    end
  endtask

  task automatic t_reset();
    chk("R1 dout", dout, 12'h000);
    chk("R1 cal_active", {11'd0, cal_active}, 12'h000);
  endtask

  task automatic t_disabled();
    wr_hold(12'h5A5); tick(); tick();
    chk("R4 off holds zero", dout, 12'h000);
    pulse_sw();
    chk("R4 off ignores trigger", dout, 12'h000);
  endtask

  task automatic t_direct();
    wr_ctl(1, 0, 0, 7, 0, 0);
    wr_hold(12'h123);
    chk("R5 lag one edge", dout, 12'h5A5);
    tick();
    chk("R5 follows hold (R2 on bit)", dout, 12'h123);
    ext_trig = 7'h7F; sw_trig = 1'b1; tick(); ext_trig = '0; sw_trig = 1'b0; tick();
    chk("R5 triggers ignored", dout, 12'h123);
  endtask

  task automatic t_cal_lock();
    wr_ctl(0, 0, 0, 0, 0, 0);
    chk("R3 write while on ignored", {11'd0, cal_active}, 12'h000);
    wr_ctl(0, 1, 0, 0, 0, 0);
    chk("R3 set while off", {11'd0, cal_active}, 12'h001);
    wr_ctl(1, 1, 0, 0, 0, 0);
    wr_ctl(1, 0, 0, 0, 0, 0);
    chk("R3 clear while on ignored", {11'd0, cal_active}, 12'h001);
    wr_ctl(0, 0, 0, 0, 0, 0);
    chk("R3 switch-off write still locked", {11'd0, cal_active}, 12'h001);
    wr_ctl(0, 0, 0, 0, 0, 0);
    chk("R3 clear while off", {11'd0, cal_active}, 12'h000);
  endtask

  task automatic t_sw_trig();
    wr_ctl(0, 0, 0, 0, 0, 0);
    wr_ctl(1, 0, 1, 7, 0, 0);
    wr_hold(12'h456); tick();
    chk("R6 no trigger no update", dout, 12'h000);
    ext_trig = 7'h7F; tick(); ext_trig = '0; tick();
    chk("R6 external ignored on code 7", dout, 12'h000);
    pulse_sw();
    chk("R6 R7 software trigger same edge", dout, 12'h456);
  endtask

  task automatic t_ext_trig();
    wr_ctl(1, 0, 1, 2, 0, 0);
    wr_hold(12'h321);
    ext_trig[1] = 1'b1; tick(); ext_trig[1] = 1'b0; tick();
    chk("R6 other line ignored", dout, 12'h456);
    pulse_sw();
    chk("R6 software ignored on code 2", dout, 12'h456);
    ext_trig[2] = 1'b1; tick();
    chk("R6 rising edge of line 2", dout, 12'h321);
    wr_hold(12'h222); tick();
    chk("R6 held line fires once", dout, 12'h321);
    ext_trig[2] = 1'b0; tick(); ext_trig[2] = 1'b1; tick(); ext_trig[2] = 1'b0;
    chk("R6 second edge", dout, 12'h222);
  endtask

  task automatic t_noise();
    wr_ctl(0, 0, 0, 0, 0, 0);
    wr_ctl(1, 0, 1, 7, 1, 3);
    lf = 12'hACE;
    wr_hold(12'h100);
    for (int i = 0; i < 6; i++) begin
      pulse_sw(); lf = lf_next(lf);
      chk("R8 R9 noise mask code 3", dout, 12'(hold + (lf & mask_of(3))));
    end
    wr_ctl(1, 0, 1, 7, 1, 15);
    wr_hold(12'hF00);
    for (int i = 0; i < 4; i++) begin
      pulse_sw(); lf = lf_next(lf);
      chk("R8 R11 full mask wraps", dout, 12'(hold + lf));
    end
    wr_ctl(1, 0, 1, 7, 1, 10);
    pulse_sw(); lf = lf_next(lf);
    chk("R9 code 10 mask 7FF", dout, 12'(hold + (lf & 12'h7FF)));
    wr_ctl(1, 0, 1, 7, 1, 11);
    pulse_sw(); lf = lf_next(lf);
    chk("R9 code 11 full mask", dout, 12'(hold + lf));
  endtask

  task automatic t_tri();
    wr_ctl(0, 0, 0, 0, 0, 0);
    wr_ctl(1, 0, 1, 7, 3, 1);
    tr = 0; up = 1'b1;
    wr_hold(12'h010);
    for (int i = 0; i < 8; i++) begin
      pulse_sw(); tri_step(1);
      chk("R10 R9 triangle peak 3", dout, 12'(hold + tr));
    end
    wr_ctl(1, 0, 1, 7, 2, 0);
    for (int i = 0; i < 4; i++) begin
      pulse_sw(); tri_step(0);
      chk("R10 mode 10 peak 1", dout, 12'(hold + tr));
    end
    wr_ctl(1, 0, 1, 7, 0, 0);
    pulse_sw();
    chk("R7 mode 00 adds nothing", dout, hold);
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    hold = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_disabled();
    t_direct();
    t_cal_lock();
    t_sw_trig();
    t_ext_trig();
    t_noise();
    t_tri();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule